// File: doc/BRIEF.md
# Signed-digit shift-add constant multiplier

This block multiplies a data word by a constant held inside it. The constant is loaded once and then reused for any number of products. On load, the constant is rewritten as signed binary digits in which no two non-zero digits sit next to each other. A run of ones becomes one addition above the run and one subtraction at its lowest bit. Two runs that have a single zero between them share their boundary term. For example, 110111 becomes +x<<6, −x<<3, −x<<0.

After a start, the block applies one signed term ±(x << s) to an accumulator per clock. The accumulator is cleared when the operation begins. The terms are taken from the lowest position upward. The block raises a done pulse after the last term. The product is kept modulo 2^DATA_W, so shifted terms that overflow give no error. The result and the number of terms used stay on the outputs until the next start.

Top module: `cmul_top`

## Requirements
- R1: After reset, busy, done, product and term_count are all zero.
- R2: When done is high, product equals x_in·K mod 2^DATA_W. x_in is the operand captured at start and K is the loaded constant, both taken as unsigned.
- R3: K is encoded in non-adjacent signed-digit form over digit positions 0..DATA_W−1. Any digit at position DATA_W is dropped because it is zero modulo 2^DATA_W. term_count equals the number of non-zero digits. Examples: 55 gives 3 terms, all-ones gives 1 term (−x), 7 gives 2 terms.
- R4: term_count never exceeds the population count of K, which is the term count of plain binary decomposition.
- R5: One term is applied per cycle. After the start edge, busy is high for exactly term_count cycles. done pulses for one cycle in the next cycle, and busy is low in that cycle.
- R6: For K = 0, busy never rises. done is high in the first cycle after the start edge, with product 0 and term_count 0.
- R7: A start pulse while busy is ignored, and the running product keeps its captured operand.
- R8: A constant load while busy is ignored. A load while idle takes effect for every later start. If a load and a start arrive in the same cycle, the start uses the previous constant.
- R9: A power-of-two constant 2^k takes exactly one term and yields x_in << k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| const_ld | input | 1 | Load const_val as the new constant (honoured only when idle) |
| const_val | input | DATA_W | Constant to load |
| start | input | 1 | Begin a product with x_in (honoured only when idle) |
| x_in | input | DATA_W | Variable operand |
| busy | output | 1 | A term is being applied this cycle |
| done | output | 1 | One-cycle pulse: product and term_count are final |
| product | output | DATA_W | Accumulated product, low DATA_W bits |
| term_count | output | $clog2(DATA_W+1) | Number of signed terms applied |

## Verification
The bench uses an 8-bit configuration. It sweeps every constant against a spread of operands and compares each product with the arithmetic product. It compares the term count with an independently computed signed-digit weight and with the population count. It also compares the number of busy cycles with the term count. A recoder that fails to merge runs split by one zero, or that keeps the digit above the top bit, reports too many terms on all-ones or on 110111 patterns. A subtraction wired as an addition gives wrong products on every constant that has a run. The constant-zero case catches a sequencer that spends a cycle on an empty plan. Pulses of start and load during a running product catch a block that re-captures its operand or constant while busy.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cmul_state_e;
endpackage

// File: rtl/cmul_recoder.sv
// Rewrites a constant into non-adjacent signed digits.
// Digit i is (3K)[i+1] - K[i+1]; (3K)>>1 equals K + (K>>1).
// The digit above the top bit is never formed (zero mod 2^W).
module cmul_recoder #(
  parameter int W = 32
) (
  input  logic [W-1:0] k_in,
  output logic [W-1:0] plus_mask,
  output logic [W-1:0] minus_mask
);
  logic [W-1:0] k_half;
  logic [W-1:0] tri_half;
  logic [W-1:0] nonzero;

  always_comb begin
    k_half   = {1'b0, k_in[W-1:1]};
    tri_half = k_in + k_half;
    nonzero  = tri_half ^ k_half;
  end

  for (genvar i = 0; i < W; i++) begin : g_digit
    assign plus_mask[i]  = nonzero[i] &  tri_half[i];
    assign minus_mask[i] = nonzero[i] & ~tri_half[i];
  end
endmodule

// File: rtl/cmul_lowbit.sv
// Picks the lowest pending digit position.
module cmul_lowbit #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  pend,
  output logic [W-1:0]  pick_oh,
  output logic [IW-1:0] pick_idx
);
  always_comb begin
    pick_oh = pend & (~pend + W'(1));
  end

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (pick_oh[i]) pick_idx = pick_idx | IW'(i);
    end
  end
endmodule

// File: rtl/cmul_accum.sv
// Forms acc +/- (x << s), wrapping modulo 2^W.
module cmul_accum #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  acc,
  input  logic [W-1:0]  xop,
  input  logic [IW-1:0] shamt,
  input  logic          subtract,
  output logic [W-1:0]  acc_next
);
  logic [W-1:0] term;

  always_comb begin
    term     = xop << shamt;
    acc_next = subtract ? (acc - term) : (acc + term);
  end
endmodule

// File: rtl/cmul_top.sv
module cmul_top #(
  parameter int DATA_W = 32,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              const_ld,
  input  logic [DATA_W-1:0] const_val,
  input  logic              start,
  input  logic [DATA_W-1:0] x_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] product,
  output logic [CNT_W-1:0]  term_count
);
  import cmul_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // stored recoded plan
  logic [DATA_W-1:0] rec_plus, rec_minus;
  logic [DATA_W-1:0] plan_plus_q, plan_minus_q;
  logic              plan_en;

  cmul_recoder #(.W(DATA_W)) u_recoder (
    .k_in      (const_val),
    .plus_mask (rec_plus),
    .minus_mask(rec_minus)
  );

  // working state
  cmul_state_e       state_q, state_d;
  logic [DATA_W-1:0] pend_plus_q, pend_plus_d;
  logic [DATA_W-1:0] pend_minus_q, pend_minus_d;
  logic [DATA_W-1:0] xop_q, xop_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              work_en;

  logic [DATA_W-1:0] pend_all;
  logic [DATA_W-1:0] sel_oh;
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_neg;
  logic [DATA_W-1:0] acc_step;
  logic              take_start;

  assign pend_all = pend_plus_q | pend_minus_q;

  cmul_lowbit #(.W(DATA_W), .IW(IDX_W)) u_lowbit (
    .pend    (pend_all),
    .pick_oh (sel_oh),
    .pick_idx(sel_idx)
  );

  assign sel_neg = |(sel_oh & pend_minus_q);

  cmul_accum #(.W(DATA_W), .IW(IDX_W)) u_accum (
    .acc     (acc_q),
    .xop     (xop_q),
    .shamt   (sel_idx),
    .subtract(sel_neg),
    .acc_next(acc_step)
  );

  assign take_start = start & (state_q == ST_IDLE);
  assign plan_en    = const_ld & (state_q == ST_IDLE);

  // next-state logic
  always_comb begin
    state_d      = state_q;
    pend_plus_d  = pend_plus_q;
    pend_minus_d = pend_minus_q;
    xop_d        = xop_q;
    acc_d        = acc_q;
    cnt_d        = cnt_q;
    done_d       = 1'b0;
    work_en      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_start) begin
          work_en      = 1'b1;
          pend_plus_d  = plan_plus_q;
          pend_minus_d = plan_minus_q;
          xop_d        = x_in;
          acc_d        = '0;
          cnt_d        = '0;
          if ((plan_plus_q | plan_minus_q) == '0) done_d = 1'b1;
          else                                     state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        work_en      = 1'b1;
        acc_d        = acc_step;
        cnt_d        = cnt_q + CNT_W'(1);
        pend_plus_d  = pend_plus_q  & ~sel_oh;
        pend_minus_d = pend_minus_q & ~sel_oh;
        if (((pend_plus_q | pend_minus_q) & ~sel_oh) == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      plan_plus_q  <= '0;
      plan_minus_q <= '0;
    end else if (plan_en) begin
      plan_plus_q  <= rec_plus;
      plan_minus_q <= rec_minus;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q      <= ST_IDLE;
      pend_plus_q  <= '0;
      pend_minus_q <= '0;
      xop_q        <= '0;
      acc_q        <= '0;
      cnt_q        <= '0;
    end else if (work_en) begin
      state_q      <= state_d;
      pend_plus_q  <= pend_plus_d;
      pend_minus_q <= pend_minus_d;
      xop_q        <= xop_d;
      acc_q        <= acc_d;
      cnt_q        <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= done_d;
  end

  assign busy       = (state_q == ST_RUN);
  assign done       = done_q;
  assign product    = acc_q;
  assign term_count = cnt_q;

  // assertions
  a_r3_non_adjacent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (((plan_plus_q | plan_minus_q) & ((plan_plus_q | plan_minus_q) >> 1)) == '0)
      && ((plan_plus_q & plan_minus_q) == '0));

  a_r3_single_term: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> ($onehot0(sel_oh) && (sel_oh != '0)));

  a_r5_one_term_per_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> done_q);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> (!busy && (pend_all == '0)));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> (cnt_q < CNT_W'(DATA_W)));

  a_r6_zero_plan: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_q && (cnt_q == '0)) |-> (acc_q == '0));

  a_r7_operand_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start) |=> (xop_q == $past(xop_q)));

  a_r8_plan_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && const_ld) |=> ($stable(plan_plus_q) && $stable(plan_minus_q)));
endmodule

// File: tb/tb_cmul_top.sv
module tb_cmul_top;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          const_ld;
  logic [W-1:0]  const_val;
  logic          start;
  logic [W-1:0]  x_in;
  logic          busy, done;
  logic [W-1:0]  product;
  logic [CW-1:0] term_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmul_top #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .const_ld(const_ld), .const_val(const_val),
    .start(start), .x_in(x_in), .busy(busy), .done(done),
    .product(product), .term_count(term_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popc(input int m);
    int c = 0;
    for (int i = 0; i < W; i++) c += (m >> i) & 1;
    return c;
  endfunction

  // serial signed-digit weight, digits 0..W-1 only
  function automatic int sd_weight(input int m);
    int v = m;
    int w = 0;
    for (int i = 0; i < W; i++) begin
      if (v % 2 == 1) begin
        w++;
        if (v % 4 == 3) v = v + 1;
        else            v = v - 1;
      end
      v = v >> 1;
    end
    return w;
  endfunction

  function automatic int xpat(input int k);
    case (k)
      0: return 0;      1: return 1;      2: return 255;   3: return 128;
      4: return 85;     5: return 170;    6: return 127;   default: return 60;
    endcase
  endfunction

  task automatic load(input int m);
    @(negedge clk);
    const_ld = 1'b1; const_val = W'(m);
    @(negedge clk);
    const_ld = 1'b0;
  endtask

  // start a product, wait for done; returns busy-cycle count
  task automatic run(input int x, output int cyc, output bit hung);
    int guard = 0;
    cyc = 0; hung = 1'b0;
    @(negedge clk);
    start = 1'b1; x_in = W'(x);
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 100) begin
      if (busy) cyc++;
      @(negedge clk);
      guard++;
    end
    if (!done) hung = 1'b1;
  endtask

  task automatic full_check(input int m, input int x, input string tag);
    int cyc; bit hung; int exp_p; int exp_t;
    run(x, cyc, hung);
    exp_p = (m * x) & ((1 << W) - 1);
    exp_t = sd_weight(m);
    check(!hung, {tag, " R5 done seen"}, int'(hung), 0);
    check(int'(product) == exp_p, {tag, " R2 product"}, int'(product), exp_p);
    check(int'(term_count) == exp_t, {tag, " R3 term count"}, int'(term_count), exp_t);
    check(int'(term_count) <= popc(m), {tag, " R4 count bound"}, int'(term_count), popc(m));
    check(cyc == exp_t, {tag, " R5 busy cycles"}, cyc, exp_t);
    check(!busy, {tag, " R5 idle at done"}, int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc; bit hung; int exp_p;
    rst_n = 1'b0; const_ld = 1'b0; const_val = '0; start = 1'b0; x_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(product == '0, "R1 product", int'(product), 0);
    check(term_count == '0, "R1 term_count", int'(term_count), 0);

    // R6 zero constant: never busy, immediate done
    load(0);
    run(77, cyc, hung);
    check(!hung && cyc == 0, "R6 no busy cycles", cyc, 0);
    check(product == '0 && term_count == '0, "R6 zero result", int'(product), 0);

    // R3 directed patterns
    load(55);  full_check(55, 3, "k55");
    check(int'(term_count) == 3, "R3 110111 three terms", int'(term_count), 3);
    load(255); full_check(255, 9, "kFF");
    check(int'(term_count) == 1, "R3 all-ones one term", int'(term_count), 1);
    load(7);   full_check(7, 200, "k7");
    check(int'(term_count) == 2, "R3 seven two terms", int'(term_count), 2);

    // R9 powers of two
    for (int k = 0; k < W; k++) begin
      load(1 << k);
      full_check(1 << k, 173, "pow2");
      check(int'(term_count) == 1, "R9 single term", int'(term_count), 1);
      exp_p = (173 << k) & ((1 << W) - 1);
      check(int'(product) == exp_p, "R9 shifted operand", int'(product), exp_p);
    end

    // R7/R8: disturb a running product (K=85 gives 4 terms)
    load(85);
    @(negedge clk);
    start = 1'b1; x_in = W'(3);
    @(negedge clk);
    start = 1'b1; x_in = W'(100); const_ld = 1'b1; const_val = W'(19);
    @(negedge clk);
    start = 1'b0; const_ld = 1'b0;
    while (!done) @(negedge clk);
    exp_p = (85 * 3) & ((1 << W) - 1);
    check(int'(product) == exp_p, "R7 start ignored while busy", int'(product), exp_p);
    check(int'(term_count) == 4, "R8 load ignored while busy", int'(term_count), 4);
    run(5, cyc, hung);
    exp_p = (85 * 5) & ((1 << W) - 1);
    check(int'(product) == exp_p, "R8 old constant kept", int'(product), exp_p);

    // R8 load and start together: start uses previous constant
    @(negedge clk);
    const_ld = 1'b1; const_val = W'(19); start = 1'b1; x_in = W'(2);
    @(negedge clk);
    const_ld = 1'b0; start = 1'b0;
    while (!done) @(negedge clk);
    exp_p = (85 * 2) & ((1 << W) - 1);
    check(int'(product) == exp_p, "R8 same-cycle start uses old", int'(product), exp_p);
    run(2, cyc, hung);
    check(int'(product) == 38, "R8 new constant applied", int'(product), 38);

    // R2/R3/R4/R5 exhaustive constant sweep
    for (int m = 0; m < (1 << W); m++) begin
      load(m);
      for (int k = 0; k < 8; k++) full_check(m, xpat(k), "sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule